// File: doc/BRIEF.md
# Dual-Issue Slot Aligner

This block sits between a two-instruction fetch buffer and a two-slot decoder in a short in-order pipeline. Each cycle it looks at the pair of instructions in the buffer, using simplified per-slot decode flags: validity, source and destination register numbers, register-write enable, branch, memory access and multiply. It then decides whether both slots issue, only the older slot issues, or nothing issues. It reports how far the fetch pointer must move (0, 1 or 2 instructions) and which slots become bubbles. It also reports an encoded reason whenever a slot is left unissued.

When a pair cannot issue together, the older instruction goes alone and the pointer moves by one instruction. The younger instruction therefore lands in the older slot next cycle and pairs with the following instruction. A dependency or resource clash then costs one slot rather than a full cycle. The same slide places a branch found in the younger slot into the older slot, so that it issues together with its delay-slot instruction. A branch whose delay-slot instruction is not yet in the buffer issues nothing for one cycle.

The decision is registered: inputs presented before a rising clock edge appear on the outputs after that edge. A stall input freezes the registered outputs.

Top module: `slot_aligner`

## Requirements
- R1: While reset is asserted and right after it is released, issue_o, pc_inc_o, bubble_o and cause_o are all zero.
- R2: Two valid slots with no branch in either slot, no dependency and no shared unit issue together. After the next edge the outputs are issue_o=2'b11, pc_inc_o=2, cause_o=0 (none), and pc_inc_o always equals the number of issued slots. A memory operation paired with a multiply counts as no shared unit.
- R3: If slot 0 writes register d (write enable high) and either source field of slot 1 equals d, only slot 0 issues: issue_o=2'b01, pc_inc_o=1, cause_o=1 (dependency). With slot 0 write enable low there is no dependency. Source fields are packed with source A in bits [4:0] and source B in bits [9:5].
- R4: A slot-0 destination of register 0 never creates a dependency, even when slot 1 reads register 0.
- R5: A branch in slot 1, with a non-branch in slot 0, issues slot 0 alone: issue_o=2'b01, pc_inc_o=1, cause_o=2 (branch align).
- R6: A branch in slot 0 issues as a pair with slot 1 (issue_o=2'b11, pc_inc_o=2, cause_o=0) when the delay-slot-available input is high and slot 1 is valid. This holds whatever dependency or unit clash the pair has.
- R7: A branch in slot 0 issues nothing when the delay-slot-available input is low or slot 1 is invalid: issue_o=2'b00, pc_inc_o=0, cause_o=5 (delay-slot wait).
- R8: Two memory operations in one non-branch pair are split: issue_o=2'b01, pc_inc_o=1, cause_o=3 (memory pair).
- R9: Two multiplies in one non-branch pair are split: issue_o=2'b01, pc_inc_o=1, cause_o=4 (multiply pair).
- R10: When several split reasons hold at once, the reported cause follows the priority branch align > dependency > memory pair > multiply pair.
- R11: An invalid slot 0 gives issue_o=2'b00, pc_inc_o=0, cause_o=6 (empty). A valid non-branch slot 0 with an invalid slot 1 gives issue_o=2'b01, pc_inc_o=1, cause_o=6. After reset, bit k of bubble_o is 1 exactly when slot k did not issue.
- R12: While stall_i is high at a clock edge, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold all outputs this cycle |
| s0_vld_i | input | 1 | Slot 0 holds an instruction |
| s0_src_i | input | 10 | Slot 0 source registers (A in [4:0], B in [9:5]) |
| s0_dst_i | input | 5 | Slot 0 destination register |
| s0_wen_i | input | 1 | Slot 0 writes its destination |
| s0_br_i | input | 1 | Slot 0 is a branch |
| s0_mem_i | input | 1 | Slot 0 is a load or store |
| s0_mul_i | input | 1 | Slot 0 is a multiply |
| s1_vld_i | input | 1 | Slot 1 holds an instruction |
| s1_src_i | input | 10 | Slot 1 source registers (A in [4:0], B in [9:5]) |
| s1_dst_i | input | 5 | Slot 1 destination register |
| s1_wen_i | input | 1 | Slot 1 writes its destination |
| s1_br_i | input | 1 | Slot 1 is a branch |
| s1_mem_i | input | 1 | Slot 1 is a load or store |
| s1_mul_i | input | 1 | Slot 1 is a multiply |
| ds_avail_i | input | 1 | Delay-slot instruction is present in the buffer |
| issue_o | output | 2 | Bit k: slot k issues |
| pc_inc_o | output | 2 | Fetch pointer advance in instructions (0, 1, 2) |
| bubble_o | output | 2 | Bit k: slot k left as a bubble |
| cause_o | output | 3 | Reason a slot was not issued (encoding in R2 to R11) |

## Verification
Several split reasons can be present in the same pair. A younger-slot branch can coincide with a dependency and a memory clash, and a dependency can coincide with both unit clashes. The vector table builds such pairs on purpose and checks that one slot still issues with a one-instruction advance and that the cause follows the fixed priority. A second overlap is an older-slot branch whose pair also carries a dependency and two memory operations, which must still issue together. A stall arriving while a split pair waits at the input is also checked, by confirming that the old decision stays frozen and the split only appears after release.

// File: rtl/slot_aligner_pkg.sv
package slot_aligner_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_RAW      = 3'd1,
        CAUSE_BR_ALIGN = 3'd2,
        CAUSE_MEM_PAIR = 3'd3,
        CAUSE_MUL_PAIR = 3'd4,
        CAUSE_DS_WAIT  = 3'd5,
        CAUSE_EMPTY    = 3'd6
    } hold_cause_e;

    // Reasons a non-branch pair cannot go out together
    typedef struct packed {
        logic br_young;
        logic raw;
        logic mem_both;
        logic mul_both;
    } pair_flags_t;

    // Registered issue decision
    typedef struct packed {
        logic [1:0]  issue;
        logic [1:0]  pc_inc;
        logic [1:0]  bubble;
        hold_cause_e cause;
    } issue_state_t;

endpackage

// File: rtl/sa_raw_detect.sv
module sa_raw_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_AW-1:0]         prod_dst_i,
    input  logic                      prod_wen_i,
    input  logic [REG_AW*NUM_SRC-1:0] cons_src_i,
    output logic                      hit_o
);
    logic [NUM_SRC-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign match[g] = (cons_src_i[g*REG_AW +: REG_AW] == prod_dst_i);
        end
    endgenerate

    // Register zero is a constant sink and never carries a value forward
    assign hit_o = prod_wen_i && (prod_dst_i != '0) && (|match);
endmodule

// File: rtl/sa_pair_rules.sv
module sa_pair_rules
    import slot_aligner_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_AW-1:0]         s0_dst_i,
    input  logic                      s0_wen_i,
    input  logic                      s0_mem_i,
    input  logic                      s0_mul_i,
    input  logic [REG_AW*NUM_SRC-1:0] s1_src_i,
    input  logic                      s1_br_i,
    input  logic                      s1_mem_i,
    input  logic                      s1_mul_i,
    output pair_flags_t               flags_o
);
    logic raw_hit;

    sa_raw_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) raw_i (
        .prod_dst_i (s0_dst_i),
        .prod_wen_i (s0_wen_i),
        .cons_src_i (s1_src_i),
        .hit_o      (raw_hit)
    );

    always_comb begin
        flags_o.br_young = s1_br_i;
        flags_o.raw      = raw_hit;
        flags_o.mem_both = s0_mem_i && s1_mem_i;
        flags_o.mul_both = s0_mul_i && s1_mul_i;
    end
endmodule

// File: rtl/slot_aligner.sv
module slot_aligner
    import slot_aligner_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stall_i,
    input  logic                      s0_vld_i,
    input  logic [REG_AW*NUM_SRC-1:0] s0_src_i,
    input  logic [REG_AW-1:0]         s0_dst_i,
    input  logic                      s0_wen_i,
    input  logic                      s0_br_i,
    input  logic                      s0_mem_i,
    input  logic                      s0_mul_i,
    input  logic                      s1_vld_i,
    input  logic [REG_AW*NUM_SRC-1:0] s1_src_i,
    input  logic [REG_AW-1:0]         s1_dst_i,
    input  logic                      s1_wen_i,
    input  logic                      s1_br_i,
    input  logic                      s1_mem_i,
    input  logic                      s1_mul_i,
    input  logic                      ds_avail_i,
    output logic [1:0]                issue_o,
    output logic [1:0]                pc_inc_o,
    output logic [1:0]                bubble_o,
    output logic [2:0]                cause_o
);
    localparam int SRC_W = REG_AW * NUM_SRC;

    pair_flags_t  flags;
    issue_state_t state_d, state_q;

    // Slot 0 sources and slot 1 destination matter only to later stages
    logic unused_ok;
    assign unused_ok = ^{s0_src_i, s1_dst_i, s1_wen_i, SRC_W[0]};

    sa_pair_rules #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) rules_i (
        .s0_dst_i (s0_dst_i),
        .s0_wen_i (s0_wen_i),
        .s0_mem_i (s0_mem_i),
        .s0_mul_i (s0_mul_i),
        .s1_src_i (s1_src_i),
        .s1_br_i  (s1_br_i),
        .s1_mem_i (s1_mem_i),
        .s1_mul_i (s1_mul_i),
        .flags_o  (flags)
    );

    always_comb begin
        state_d = state_q;
        if (!stall_i) begin
            state_d.issue  = 2'b00;
            state_d.pc_inc = 2'd0;
            state_d.bubble = 2'b11;
            state_d.cause  = CAUSE_NONE;
            if (!s0_vld_i) begin
                state_d.cause = CAUSE_EMPTY;
            end else if (s0_br_i) begin
                if (ds_avail_i && s1_vld_i) begin
                    state_d.issue  = 2'b11;
                    state_d.pc_inc = 2'd2;
                    state_d.bubble = 2'b00;
                end else begin
                    state_d.cause = CAUSE_DS_WAIT;
                end
            end else if (!s1_vld_i) begin
                state_d.issue  = 2'b01;
                state_d.pc_inc = 2'd1;
                state_d.bubble = 2'b10;
                state_d.cause  = CAUSE_EMPTY;
            end else if (|flags) begin
                // slide by one slot; younger instruction moves up next cycle
                state_d.issue  = 2'b01;
                state_d.pc_inc = 2'd1;
                state_d.bubble = 2'b10;
                if (flags.br_young)      state_d.cause = CAUSE_BR_ALIGN;
                else if (flags.raw)      state_d.cause = CAUSE_RAW;
                else if (flags.mem_both) state_d.cause = CAUSE_MEM_PAIR;
                else                     state_d.cause = CAUSE_MUL_PAIR;
            end else begin
                state_d.issue  = 2'b11;
                state_d.pc_inc = 2'd2;
                state_d.bubble = 2'b00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{issue: 2'b00, pc_inc: 2'd0, bubble: 2'b00, cause: CAUSE_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign issue_o  = state_q.issue;
    assign pc_inc_o = state_q.pc_inc;
    assign bubble_o = state_q.bubble;
    assign cause_o  = state_q.cause;
endmodule

// File: rtl/slot_aligner_chk.sv
module slot_aligner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stall_i,
    input logic       s0_vld_i,
    input logic       s0_br_i,
    input logic       s0_mem_i,
    input logic       s0_mul_i,
    input logic       s1_vld_i,
    input logic       s1_br_i,
    input logic       s1_mem_i,
    input logic       s1_mul_i,
    input logic       ds_avail_i,
    input logic [1:0] issue_o,
    input logic [1:0] pc_inc_o,
    input logic [1:0] bubble_o,
    input logic [2:0] cause_o
);
    assert_young_needs_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o[1] |-> issue_o[0]);

    assert_pcinc_counts_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o == 2'($countones(issue_o)));

    assert_young_branch_slides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && s0_vld_i && !s0_br_i && s1_vld_i && s1_br_i)
        |=> (issue_o == 2'b01 && cause_o == 3'd2));

    assert_ds_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && s0_vld_i && s0_br_i && !(ds_avail_i && s1_vld_i))
        |=> (issue_o == 2'b00 && pc_inc_o == 2'd0));

    assert_mem_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && s0_vld_i && !s0_br_i && s1_vld_i && s0_mem_i && s1_mem_i)
        |=> (issue_o == 2'b01));

    assert_mul_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && s0_vld_i && !s0_br_i && s1_vld_i && s0_mul_i && s1_mul_i)
        |=> (issue_o == 2'b01));

    assert_bubble_mirror_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o != 3'd0 || issue_o == 2'b11) |-> (bubble_o == ~issue_o));

    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable({issue_o, pc_inc_o, bubble_o, cause_o}));
endmodule

bind slot_aligner slot_aligner_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .s0_vld_i   (s0_vld_i),
    .s0_br_i    (s0_br_i),
    .s0_mem_i   (s0_mem_i),
    .s0_mul_i   (s0_mul_i),
    .s1_vld_i   (s1_vld_i),
    .s1_br_i    (s1_br_i),
    .s1_mem_i   (s1_mem_i),
    .s1_mul_i   (s1_mul_i),
    .ds_avail_i (ds_avail_i),
    .issue_o    (issue_o),
    .pc_inc_o   (pc_inc_o),
    .bubble_o   (bubble_o),
    .cause_o    (cause_o)
);

// File: tb/slot_aligner_tb.sv
module slot_aligner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NV         = 17;

    typedef struct packed {
        logic       v;
        logic [9:0] src;
        logic [4:0] dst;
        logic       wen;
        logic       br;
        logic       mem;
        logic       mul;
    } slot_t;

    typedef struct packed {
        slot_t      s0;
        slot_t      s1;
        logic       ds;
        logic [1:0] issue;
        logic [1:0] pc;
        logic [2:0] cause;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R2 independent pair
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b11, 2'd2, 3'd0, 4'd2},
        // R3 dependency on source A
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd9, 5'd4}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd1, 4'd3},
        // R3 dependency on source B
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd4, 5'd9}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd1, 4'd3},
        // R4 register zero never a dependency
        '{'{1'b1, {5'd3, 5'd1}, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd0, 5'd0}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b11, 2'd2, 3'd0, 4'd4},
        // R3 write enable low: no dependency
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd4, 5'd4}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b11, 2'd2, 3'd0, 4'd3},
        // R5 branch in slot 1
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd2, 4'd5},
        // R6 slot-0 branch with delay slot, despite dependency and two memory ops
        '{'{1'b1, {5'd2, 5'd1}, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0}, '{1'b1, {5'd4, 5'd4}, 5'd8, 1'b1, 1'b0, 1'b1, 1'b0}, 1'b1, 2'b11, 2'd2, 3'd0, 4'd6},
        // R7 slot-0 branch, delay slot not available
        '{'{1'b1, {5'd2, 5'd1}, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b00, 2'd0, 3'd5, 4'd7},
        // R8 two memory ops
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b0, 1'b0, 1'b1, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd3, 4'd8},
        // R9 two multiplies
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b1}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b1}, 1'b0, 2'b01, 2'd1, 3'd4, 4'd9},
        // R10 branch align beats dependency and memory pair
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0}, '{1'b1, {5'd4, 5'd2}, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd2, 4'd10},
        // R10 dependency beats memory and multiply pair
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b1, 1'b1}, '{1'b1, {5'd2, 5'd4}, 5'd7, 1'b1, 1'b0, 1'b1, 1'b1}, 1'b0, 2'b01, 2'd1, 3'd1, 4'd10},
        // R10 memory pair beats multiply pair
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b1, 1'b1}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b1, 1'b1}, 1'b0, 2'b01, 2'd1, 3'd3, 4'd10},
        // R11 slot 0 empty
        '{'{1'b0, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b00, 2'd0, 3'd6, 4'd11},
        // R11 slot 1 empty
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0}, '{1'b0, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, 2'b01, 2'd1, 3'd6, 4'd11},
        // R7 slot-0 branch, flag high but slot 1 invalid
        '{'{1'b1, {5'd2, 5'd1}, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0}, '{1'b0, {5'd6, 5'd5}, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1, 2'b00, 2'd0, 3'd5, 4'd7},
        // R2 memory op with multiply pairs fine
        '{'{1'b1, {5'd3, 5'd1}, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0}, '{1'b1, {5'd6, 5'd5}, 5'd7, 1'b1, 1'b0, 1'b0, 1'b1}, 1'b0, 2'b11, 2'd2, 3'd0, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0;
    slot_t      s0 = '0;
    slot_t      s1 = '0;
    logic       ds = 1'b0;
    logic [1:0] issue, pc_inc, bubble;
    logic [2:0] cause;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_aligner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_i    (stall),
        .s0_vld_i   (s0.v),
        .s0_src_i   (s0.src),
        .s0_dst_i   (s0.dst),
        .s0_wen_i   (s0.wen),
        .s0_br_i    (s0.br),
        .s0_mem_i   (s0.mem),
        .s0_mul_i   (s0.mul),
        .s1_vld_i   (s1.v),
        .s1_src_i   (s1.src),
        .s1_dst_i   (s1.dst),
        .s1_wen_i   (s1.wen),
        .s1_br_i    (s1.br),
        .s1_mem_i   (s1.mem),
        .s1_mul_i   (s1.mul),
        .ds_avail_i (ds),
        .issue_o    (issue),
        .pc_inc_o   (pc_inc),
        .bubble_o   (bubble),
        .cause_o    (cause)
    );

    // got/exp packed as {issue, pc_inc, bubble, cause}
    task automatic check(input string req, input int idx, input logic [8:0] got, input logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s case %0d: actual issue=%b pc=%0d bubble=%b cause=%0d expected issue=%b pc=%0d bubble=%b cause=%0d",
                     req, idx, got[8:7], got[6:5], got[4:3], got[2:0], exp[8:7], exp[6:5], exp[4:3], exp[2:0]);
        end
    endtask

    task automatic apply(input int k);
        s0 = VECS[k].s0;
        s1 = VECS[k].s1;
        ds = VECS[k].ds;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=still running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs cleared under reset
        check("R1", 0, {issue, pc_inc, bubble, cause}, 9'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 still cleared after release with idle inputs? inputs all zero -> empty slot 0
        check("R11", 0, {issue, pc_inc, bubble, cause}, {2'b00, 2'd0, 2'b11, 3'd6});

        for (int k = 0; k < NV; k++) begin
            apply(k);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", VECS[k].req), k, {issue, pc_inc, bubble, cause},
                  {VECS[k].issue, VECS[k].pc, ~VECS[k].issue, VECS[k].cause});
        end

        // R12 stall freezes a dual-issue decision while a split pair waits
        apply(0);
        @(posedge clk);
        @(negedge clk);
        check("R2", 100, {issue, pc_inc, bubble, cause}, {2'b11, 2'd2, 2'b00, 3'd0});
        apply(8);
        stall = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12", 101, {issue, pc_inc, bubble, cause}, {2'b11, 2'd2, 2'b00, 3'd0});
        stall = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8", 102, {issue, pc_inc, bubble, cause}, {2'b01, 2'd1, 2'b10, 3'd3});

        // R1 mid-run reset clears state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", 103, {issue, pc_inc, bubble, cause}, 9'b0);
        rst_n = 1'b1;
        apply(6);
        @(posedge clk);
        @(negedge clk);
        check("R6", 104, {issue, pc_inc, bubble, cause}, {2'b11, 2'd2, 2'b00, 3'd0});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule